// File: doc/BRIEF.md
# Hot-Plug Slot Fault Status Register

This block holds the status and fault bookkeeping for one slot of a hot-plug power controller. The slot has two main rails (+12V and +3.3V) and an auxiliary rail. Upstream current-sense logic reports overcurrent as single-cycle event pulses, one per rail. From those pulses, from the slot enable inputs and from an active-low force-on input, the block keeps three sticky overcurrent flags. It also keeps two fault-pin latches, one for the main pair of rails and one for the auxiliary rail. It reports whether main and auxiliary power are on, drives an active-low open-drain fault pin and raises an interrupt.

Software reaches the block over a byte-wide register bus. The status byte is at command address 05h. Reads have no side effects. A write clears each sticky flag whose data bit is 1. The fault-pin latches ignore register traffic and clear only when the matching enable input goes low. The force-on input releases the pin, but the status byte still shows the underlying fault condition.

Top module: `hp_slot_status`

## Requirements
- R1: After a synchronous reset the status byte reads 00h, `main_pwr_on` and `aux_pwr_on` are 0, `fault_n` is 1 (released) and `irq` is 0.
- R2: A read at address 05h returns, one cycle later, bit7 = fault-pin latch (1 while a main or aux latch is set), bit6 = main power on, bit5 = aux power on, bit4 = aux overcurrent flag, bit2 = +12V overcurrent flag and bit0 = +3.3V overcurrent flag. Bits 3 and 1 always read 0. A read at any other address returns 00h.
- R3: An overcurrent pulse sets its sticky flag at the next clock edge. `irq` is the registered OR of the three flags.
- R4: A write to address 05h clears each flag whose data bit (4, 2 or 0) is 1. Data bits of 0 leave the flags unchanged. Writes to other addresses have no effect. `irq` falls once all flags are clear.
- R5: An overcurrent pulse in the same cycle as a clearing write to that flag leaves the flag set.
- R6: A +12V or +3.3V pulse while `en_main` is high sets the main latch and drives `fault_n` low. The latch stays set through reads and flag clears, and clears only when `en_main` is low.
- R7: An aux pulse while `en_aux` is high sets the aux latch, which clears only when `en_aux` is low. With both latches set, `fault_n` stays low until both enables have gone low.
- R8: While `force_on_n` is 0, `fault_n` is 1. Status bit7 still shows the latch state. `fault_n` drops again one cycle after `force_on_n` returns high if a latch is still set.
- R9: `main_pwr_on` equals `en_main` with no main latch set, and `aux_pwr_on` equals `en_aux` with no aux latch set. After a fault, power returns only after the enable has gone low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register command address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (1 = clear the flag) |
| bus_rdata | output | 8 | Registered read data |
| oc12_evt | input | 1 | +12V overcurrent event pulse |
| oc3v3_evt | input | 1 | +3.3V overcurrent event pulse |
| ocaux_evt | input | 1 | Auxiliary overcurrent event pulse |
| en_main | input | 1 | Main rails enable, active high |
| en_aux | input | 1 | Auxiliary rail enable, active high |
| force_on_n | input | 1 | Force-on, active low; releases the fault pin |
| main_pwr_on | output | 1 | Main rails power state |
| aux_pwr_on | output | 1 | Auxiliary rail power state |
| fault_n | output | 1 | Fault pin: 0 = pulled low, 1 = released |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
Every state element in this block is visible at the ports within one cycle. A wrong sticky flag shows on `irq` and in the next status read. A wrong latch shows on `fault_n` and on the power outputs at the next edge. The bench therefore walks through sequences that separate the two kinds of storage: clearing flags while the latches hold, dropping one enable while the other domain still holds the pin, and forcing the pin released while bit7 stays set. It also drives an event in the same cycle as a clearing write, and it writes zeros and writes to a wrong address to confirm that nothing changes.

// File: rtl/hp_status_pkg.sv
package hp_status_pkg;

  // Status byte field positions (software decodes these)
  localparam int BIT_PIN   = 7;
  localparam int BIT_MAIN  = 6;
  localparam int BIT_AUX   = 5;
  localparam int BIT_OCAUX = 4;
  localparam int BIT_OC12  = 2;
  localparam int BIT_OC3V3 = 0;

  // Sticky flag indices
  typedef enum logic [1:0] {
    RAIL_3V3 = 2'd0,
    RAIL_12V = 2'd1,
    RAIL_AUX = 2'd2
  } rail_e;

  localparam int NUM_RAILS = 3;

  // Bit position in the status byte for each sticky flag
  function automatic int rail_bit(input int idx);
    case (idx)
      0:       return BIT_OC3V3;
      1:       return BIT_OC12;
      default: return BIT_OCAUX;
    endcase
  endfunction

endpackage

// File: rtl/hp_sticky_flags.sv
module hp_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_d,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    // Event beats clear
    assign flag_d[i] = set_evt[i] | (flag_q[i] & ~clr[i]);

    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_d[i];
    end

    p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
      set_evt[i] |=> flag_q[i]);

    p_clr_clears_r4: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set_evt[i]) |=> !flag_q[i]);

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr[i] && !set_evt[i]) |=> $stable(flag_q[i]));
  end

endmodule

// File: rtl/hp_domain_latch.sv
module hp_domain_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic set_evt,
  output logic latch_d,
  output logic latch_q,
  output logic pwr_on_q
);

  // Cleared while the domain enable is low; sets on an event otherwise
  assign latch_d = en & (latch_q | set_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= 1'b0;
      pwr_on_q <= 1'b0;
    end else begin
      latch_q  <= latch_d;
      pwr_on_q <= en & ~latch_d;
    end
  end

  p_en_low_resets_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !latch_q);

  p_no_power_in_fault_r9: assert property (@(posedge clk) disable iff (rst)
    latch_q |-> !pwr_on_q);

  p_hold_while_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    (en && latch_q) |=> latch_q);

endmodule

// File: rtl/hp_status_readout.sv
module hp_status_readout #(
  parameter int                 ADDR_W   = 8,
  parameter int                 DATA_W   = 8,
  parameter logic [ADDR_W-1:0]  CMD_ADDR = 'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] status_in,
  output logic [DATA_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst)                        rdata <= '0;
    else if (rd && addr == CMD_ADDR) rdata <= status_in;
    else if (rd)                    rdata <= '0;
  end

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rdata[3] == 1'b0 && rdata[1] == 1'b0);

  p_other_addr_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd && addr != CMD_ADDR) |=> rdata == '0);

endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
  import hp_status_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              oc12_evt,
  input  logic              oc3v3_evt,
  input  logic              ocaux_evt,
  input  logic              en_main,
  input  logic              en_aux,
  input  logic              force_on_n,
  output logic              main_pwr_on,
  output logic              aux_pwr_on,
  output logic              fault_n,
  output logic              irq
);

  localparam logic [DATA_W-1:0] CLR_MASK =
    DATA_W'((1 << BIT_OC3V3) | (1 << BIT_OC12) | (1 << BIT_OCAUX));

  logic                 wr_hit;
  logic [NUM_RAILS-1:0] evt_vec, clr_vec, flag_d, flag_q;
  logic                 main_ld, main_lq, aux_ld, aux_lq;
  logic [DATA_W-1:0]    status_byte;
  logic                 unused_wdata;

  assign wr_hit       = bus_wr && (bus_addr == CMD_ADDR);
  assign unused_wdata = ^(bus_wdata & ~CLR_MASK);

  assign evt_vec[RAIL_3V3] = oc3v3_evt;
  assign evt_vec[RAIL_12V] = oc12_evt;
  assign evt_vec[RAIL_AUX] = ocaux_evt;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_clr
    assign clr_vec[i] = wr_hit & bus_wdata[rail_bit(i)];
  end

  hp_sticky_flags #(.N(NUM_RAILS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_evt (evt_vec),
    .clr     (clr_vec),
    .flag_d  (flag_d),
    .flag_q  (flag_q)
  );

  hp_domain_latch u_main (
    .clk      (clk),
    .rst      (rst),
    .en       (en_main),
    .set_evt  (oc12_evt | oc3v3_evt),
    .latch_d  (main_ld),
    .latch_q  (main_lq),
    .pwr_on_q (main_pwr_on)
  );

  hp_domain_latch u_aux (
    .clk      (clk),
    .rst      (rst),
    .en       (en_aux),
    .set_evt  (ocaux_evt),
    .latch_d  (aux_ld),
    .latch_q  (aux_lq),
    .pwr_on_q (aux_pwr_on)
  );

  always_comb begin
    status_byte = '0;
    status_byte[BIT_PIN]   = main_lq | aux_lq;
    status_byte[BIT_MAIN]  = main_pwr_on;
    status_byte[BIT_AUX]   = aux_pwr_on;
    for (int i = 0; i < NUM_RAILS; i++)
      status_byte[rail_bit(i)] = flag_q[i];
  end

  hp_status_readout #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CMD_ADDR (CMD_ADDR)
  ) u_read (
    .clk       (clk),
    .rst       (rst),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .status_in (status_byte),
    .rdata     (bus_rdata)
  );

  // Registered pin and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n <= 1'b1;
      irq     <= 1'b0;
    end else begin
      fault_n <= ~((main_ld | aux_ld) & force_on_n);
      irq     <= |flag_d;
    end
  end

  p_force_release_r8: assert property (@(posedge clk) disable iff (rst)
    !force_on_n |=> fault_n);

  p_irq_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    irq == (|flag_q));

  p_pin_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!fault_n && en_main && en_aux && force_on_n) |=> !fault_n);

  p_pin_needs_latch_r7: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (main_lq || aux_lq));

endmodule

// File: tb/hp_slot_status_test.sv
`timescale 1ns/1ps
module hp_slot_status_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       oc12_evt = 1'b0, oc3v3_evt = 1'b0, ocaux_evt = 1'b0;
  logic       en_main = 1'b0, en_aux = 1'b0, force_on_n = 1'b1;
  logic       main_pwr_on, aux_pwr_on, fault_n, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  hp_slot_status uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .oc12_evt(oc12_evt), .oc3v3_evt(oc3v3_evt), .ocaux_evt(ocaux_evt),
    .en_main(en_main), .en_aux(en_aux), .force_on_n(force_on_n),
    .main_pwr_on(main_pwr_on), .aux_pwr_on(aux_pwr_on),
    .fault_n(fault_n), .irq(irq)
  );

  // Scoreboard of expected read data
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag, input logic m, input logic a,
                          input logic f, input logic i);
    chk({tag, " main_pwr_on"}, main_pwr_on, m);
    chk({tag, " aux_pwr_on"}, aux_pwr_on, a);
    chk({tag, " fault_n"}, fault_n, f);
    chk({tag, " irq"}, irq, i);
  endtask

  task automatic do_read(input logic [7:0] addr, input logic [7:0] exp,
                         input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = addr;
    bus_rd   = 1'b1;
    tick();
    bus_rd   = 1'b0;
    tick();
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [7:0] data);
    bus_addr  = addr;
    bus_wdata = data;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: oc3v3_evt = 1'b1;
      1: oc12_evt  = 1'b1;
      default: ocaux_evt = 1'b1;
    endcase
    tick();
    oc3v3_evt = 1'b0; oc12_evt = 1'b0; ocaux_evt = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_outs("R1", 1'b0, 1'b0, 1'b1, 1'b0);
    do_read(8'h05, 8'h00, "R1 reset status");

    // Enable both domains
    en_main = 1'b1; en_aux = 1'b1;
    tick();
    chk_outs("R9 power up", 1'b1, 1'b1, 1'b1, 1'b0);
    do_read(8'h05, 8'h60, "R2 powered status");
    do_read(8'h06, 8'h00, "R2 other address");

    // +12V fault
    pulse(1);
    chk_outs("R3 12V fault", 1'b0, 1'b1, 1'b0, 1'b1);
    do_read(8'h05, 8'hA4, "R3 12V status");

    // Writes with no effect
    do_write(8'h05, 8'h00);
    do_write(8'h06, 8'hFF);
    tick();
    chk("R4 no-op irq", irq, 1'b1);
    do_read(8'h05, 8'hA4, "R4 no-op writes");

    // Clear 12V flag; pin latch holds
    do_write(8'h05, 8'h04);
    chk("R4 irq cleared", irq, 1'b0);
    chk("R6 pin holds after clear", fault_n, 1'b0);
    do_read(8'h05, 8'hA0, "R4 after clear");
    chk("R6 pin holds after read", fault_n, 1'b0);

    // Aux fault on top
    pulse(2);
    chk_outs("R7 aux fault", 1'b0, 1'b0, 1'b0, 1'b1);
    do_read(8'h05, 8'h90, "R7 aux status");

    // Drop main only: aux latch keeps the pin low
    en_main = 1'b0;
    tick();
    chk("R7 pin low with aux latch", fault_n, 1'b0);
    do_read(8'h05, 8'h90, "R7 main dropped");

    // Drop aux: pin released
    en_aux = 1'b0;
    tick();
    chk("R7 pin released", fault_n, 1'b1);
    do_read(8'h05, 8'h10, "R7 both dropped");
    do_write(8'h05, 8'h10);
    chk("R4 irq after aux clear", irq, 1'b0);
    do_read(8'h05, 8'h00, "R4 all clear");

    // Re-enable: power restored
    en_main = 1'b1; en_aux = 1'b1;
    tick();
    chk_outs("R9 re-enable", 1'b1, 1'b1, 1'b1, 1'b0);
    do_read(8'h05, 8'h60, "R9 re-enable status");

    // Force-on releases the pin, bit7 still set
    force_on_n = 1'b0;
    pulse(0);
    chk_outs("R8 forced", 1'b0, 1'b1, 1'b1, 1'b1);
    do_read(8'h05, 8'hA1, "R8 bit7 under force");
    force_on_n = 1'b1;
    tick();
    chk("R8 pin after force ends", fault_n, 1'b0);

    // Event and clear in the same cycle: event wins
    oc3v3_evt = 1'b1;
    do_write(8'h05, 8'h01);
    oc3v3_evt = 1'b0;
    chk("R5 irq stays", irq, 1'b1);
    do_read(8'h05, 8'hA1, "R5 event beats clear");
    do_write(8'h05, 8'h01);
    chk("R5 irq after plain clear", irq, 1'b0);
    do_read(8'h05, 8'hA0, "R5 plain clear");

    // Main latch still holds while enabled
    chk("R9 main stays off", main_pwr_on, 1'b0);
    en_main = 1'b0;
    tick();
    en_main = 1'b1;
    tick();
    chk("R9 main restored after cycle", main_pwr_on, 1'b1);
    chk("R6 pin released after cycle", fault_n, 1'b1);

    repeat (2) tick();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule